// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by an even, programmable ratio using the pulse-swallow method. A dual-modulus prescaler counts either P or P+1 fast cycles per prescaler pulse, where P is two raised to the swallow-counter width (32 by default). A swallow counter holds the long modulus for the first A prescaler pulses. A main counter closes a half period after B prescaler pulses, and a toggle stage halves the rate once more. One half period therefore lasts P*B + A fast cycles, and the divided output repeats every N = 2*(P*B + A) fast cycles.

The prescaler is plain synchronous logic clocked by the fast clock. The ratio inputs normally come from a holding register elsewhere. The divider samples them only while it is held in reset or standby, and at the end of each full output period. A reprogramming written part-way through a period therefore never shortens or stretches that period. Standby holds every counter cleared and forces the output low.

Top module: `pswallow_div`

## Requirements
- R1: With A on `swal_i` and B on `main_i`, `div_o` stays low for P*B + A fast cycles and then high for P*B + A fast cycles, repeating, so the full period is N = 2*(P*B + A) with P = 2^A_W (32 by default).
- R2: Every A from 0 to 2^A_W-1 and every B from 3 to 2^B_W-1 with B >= A gives the ratio of R1, including the smallest and largest such values.
- R3: Within each half period, each of the first A prescaler pulses spans P+1 fast cycles and each of the remaining B-A pulses spans P fast cycles.
- R4: The divider samples `swal_i` and `main_i` only while reset or standby is applied and at the falling edge of `div_o`. A change at any other time leaves the phase in progress and the following phase of the same period at the old length, and the next period uses the new values.
- R5: When `standby_i` is high at a clock edge, `div_o` is low after that edge and stays low while standby is held. After standby is released, `div_o` first rises P*B + A fast cycles later, using the A and B present at release.
- R6: Reset is synchronous and active low. After reset `div_o` is low, and the first rise comes P*B + A cycles after the first clock edge with reset released.
- R7: With the default widths, A = 16 and B = 1132 give a half period of 36240 fast cycles, so N = 72480.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| standby_i | input | 1 | Holds all counters cleared and the output low |
| swal_i | input | A_W | Swallow value A, from the holding register |
| main_i | input | B_W | Main count B, from the holding register |
| div_o | output | 1 | Divided output, period 2*(P*B + A) fast cycles |

## Verification
The bench builds one instance with A_W = 3 and B_W = 4, which makes the prescaler divide by 8 or 9. At that size every legal pairing of A and B can be swept in a few tens of thousands of cycles, including the corners A = B, A = 0, B = 3 and B = 15. Reprogramming in the low phase and in the high phase, and standby entered mid-period, are run on the same small instance. A second instance keeps the default widths of 5 and 12 bits and runs the full-size example of R7 for one complete output period.

// File: rtl/pswallow_pkg.sv
// Shared types for the pulse-swallow divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pswallow_pkg;

    // Default field widths for the swallow and main counters.
    localparam int DEF_A_W = 5;
    localparam int DEF_B_W = 12;

    // Prescaler modulus selection: short = P, long = P+1.
    typedef enum logic {
        MOD_SHORT = 1'b0,
        MOD_LONG  = 1'b1
    } mod_e;

endpackage

// File: rtl/pswallow_prescaler.sv
// Dual-modulus prescaler: emits a one-cycle tick every P or P+1 fast
// cycles, P = 2**A_W, chosen by mod_sel for the pulse being counted.
// Assumes: mod_sel is stable for the whole pulse it selects.
module pswallow_prescaler
    import pswallow_pkg::*;
#(
    parameter int A_W = DEF_A_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  mod_e mod_sel,
    output logic tick
);
    localparam int PC_W = A_W + 1;
    localparam logic [PC_W-1:0] TERM_SHORT = PC_W'((1 << A_W) - 1);
    localparam logic [PC_W-1:0] TERM_LONG  = PC_W'(1 << A_W);

    logic [PC_W-1:0] pc;

    // Terminal count depends on the selected modulus.
    always_comb begin
        tick = (mod_sel == MOD_LONG) ? (pc == TERM_LONG) : (pc == TERM_SHORT);
    end

    // Fast-cycle counter, cleared on reset, standby or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/pswallow_abcount.sv
// Swallow and main counters with the ratio holding copy.
// The swallow count selects the long modulus until A prescaler ticks
// have passed; the main count ends a half period after B ticks.
// New A and B are taken while held, and at the end of a high half.
// Assumes: B >= A and B >= 1 in the sampled values.
module pswallow_abcount
    import pswallow_pkg::*;
#(
    parameter int A_W = DEF_A_W,
    parameter int B_W = DEF_B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           pre_tick,
    input  logic           half_q,
    input  logic [A_W-1:0] swal_i,
    input  logic [B_W-1:0] main_i,
    output mod_e           mod_sel,
    output logic           half_end,
    output logic [A_W-1:0] a_q,
    output logic [B_W-1:0] b_q
);
    logic [A_W-1:0] sc;
    logic [B_W-1:0] mc;
    logic           last_tick;

    // Modulus choice and end-of-half detection.
    always_comb begin
        mod_sel   = (sc != a_q) ? MOD_LONG : MOD_SHORT;
        last_tick = (mc == B_W'(b_q - 1'b1));
        half_end  = pre_tick && last_tick;
    end

    // Counter update and boundary-only reload of the ratio copy.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            sc  <= '0;
            mc  <= '0;
            a_q <= swal_i;
            b_q <= main_i;
        end else if (pre_tick) begin
            if (last_tick) begin
                sc <= '0;
                mc <= '0;
                if (half_q) begin
                    a_q <= swal_i;
                    b_q <= main_i;
                end
            end else begin
                mc <= mc + 1'b1;
                if (mod_sel == MOD_LONG) begin
                    sc <= sc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pswallow_halver.sv
// Final divide-by-two: toggles the output at the end of every half.
// Assumes: half_end is a single-cycle strobe.
module pswallow_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic half_end,
    output logic q
);
    // Toggle flop, low during reset and standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            q <= 1'b0;
        end else if (half_end) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/pswallow_div.sv
// Top of the pulse-swallow divider: prescaler, swallow/main counters
// and the trailing divide-by-two. Output period 2*(P*B + A), P = 2**A_W.
// Assumes: 3 <= B, A <= B; ratio inputs come from a holding register.
module pswallow_div
    import pswallow_pkg::*;
#(
    parameter int A_W = DEF_A_W,
    parameter int B_W = DEF_B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           standby_i,
    input  logic [A_W-1:0] swal_i,
    input  logic [B_W-1:0] main_i,
    output logic           div_o
);
    mod_e           mod_sel;
    logic           pre_tick;
    logic           half_end;
    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;

    pswallow_prescaler #(.A_W(A_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (standby_i),
        .mod_sel (mod_sel),
        .tick    (pre_tick)
    );

    pswallow_abcount #(.A_W(A_W), .B_W(B_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (standby_i),
        .pre_tick (pre_tick),
        .half_q   (div_o),
        .swal_i   (swal_i),
        .main_i   (main_i),
        .mod_sel  (mod_sel),
        .half_end (half_end),
        .a_q      (a_q),
        .b_q      (b_q)
    );

    pswallow_halver u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (standby_i),
        .half_end (half_end),
        .q        (div_o)
    );
endmodule

// File: rtl/pswallow_div_chk.sv
// Assertion checker for pswallow_div, attached with bind below.
// Keeps its own cycle counters to time prescaler ticks and halves.
module pswallow_div_chk #(
    parameter int A_W = 5,
    parameter int B_W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           standby_i,
    input logic           div_o,
    input logic           pre_tick,
    input logic           half_end,
    input logic [A_W-1:0] a_q,
    input logic [B_W-1:0] b_q
);
    localparam int GC_W = A_W + 1;
    localparam int HW   = B_W + A_W + 1;
    localparam logic [GC_W-1:0] SPAN_S = GC_W'((1 << A_W) - 1);
    localparam logic [GC_W-1:0] SPAN_L = GC_W'(1 << A_W);

    logic [GC_W-1:0] gc;
    logic [HW-1:0]   hc;
    logic [HW-1:0]   half_exp;

    // Expected last-cycle index of a half period.
    always_comb begin
        half_exp = ({1'b0, b_q, {A_W{1'b0}}} + HW'(a_q)) - HW'(1);
    end

    // Cycles since the last prescaler tick and since the last half end.
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) begin
            gc <= '0;
            hc <= '0;
        end else begin
            gc <= pre_tick ? '0 : gc + 1'b1;
            hc <= half_end ? '0 : hc + 1'b1;
        end
    end

    AST_STANDBY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !div_o); // R5

    AST_PRE_SPAN: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
        pre_tick |-> (gc == SPAN_S || gc == SPAN_L)); // R3

    AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
        half_end |-> (hc == half_exp)); // R1

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(standby_i) && !$fell(div_o))
            |-> ($stable(a_q) && $stable(b_q))); // R4
endmodule

bind pswallow_div pswallow_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .div_o     (div_o),
    .pre_tick  (pre_tick),
    .half_end  (half_end),
    .a_q       (a_q),
    .b_q       (b_q)
);

// File: tb/test_pswallow_div.sv
// Bench: small instance swept over all legal ratios, plus one
// default-width instance for the full-size example.
module test_pswallow_div;
    localparam int SA = 3;
    localparam int SB = 4;
    localparam int SP = 1 << SA;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, sby, dout;
    logic [SA-1:0] swal;
    logic [SB-1:0] mainv;
    logic          d_rst_n, d_sby, d_out;
    logic [4:0]    d_swal;
    logic [11:0]   d_main;

    int checks = 0;
    int fails  = 0;

    pswallow_div #(.A_W(SA), .B_W(SB)) i_pswallow_div (
        .clk(clk), .rst_n(rst_n), .standby_i(sby),
        .swal_i(swal), .main_i(mainv), .div_o(dout));

    pswallow_div i_pswallow_div_dflt (
        .clk(clk), .rst_n(d_rst_n), .standby_i(d_sby),
        .swal_i(d_swal), .main_i(d_main), .div_o(d_out));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the small instance's output leaves lvl.
    task automatic phase_s(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (dout == lvl && n < 5000);
    endtask

    task automatic phase_d(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (d_out == lvl && n < 100000);
    endtask

    task automatic chk_phase(input logic lvl, input int exp, input string req);
        int n;
        phase_s(lvl, n);
        chk(n == exp, req, n, exp);
    endtask

    initial begin
        #(4 * 180000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; sby = 1'b0; swal = 3'd1; mainv = 4'd3;
        d_rst_n = 1'b0; d_sby = 1'b0; d_swal = 5'd16; d_main = 12'd1132;
        repeat (3) @(negedge clk);
        chk(dout == 1'b0, "R6 reset low", dout, 0);
        rst_n = 1'b1;
        chk_phase(1'b0, SP * 3 + 1, "R6 first rise");
        chk_phase(1'b1, SP * 3 + 1, "R1 high half");

        // R2 / R3: sweep of every legal pairing.
        for (int b = 3; b < 16; b++) begin
            for (int a = 0; a < SP; a++) begin
                if (a <= b) begin
                    sby = 1'b1; swal = SA'(a); mainv = SB'(b);
                    repeat (2) @(negedge clk);
                    sby = 1'b0;
                    chk_phase(1'b0, SP * b + a, "R2 low half");
                    chk_phase(1'b1, SP * b + a, "R3 high half");
                    chk_phase(1'b0, SP * b + a, "R1 next low half");
                end
            end
        end

        // R4: reprogram during a low phase, then during a high phase.
        sby = 1'b1; swal = 3'd1; mainv = 4'd4;
        repeat (2) @(negedge clk);
        sby = 1'b0;
        repeat (5) @(negedge clk);
        swal = 3'd5; mainv = 4'd9;
        chk_phase(1'b0, 33 - 5, "R4 low unchanged");
        chk_phase(1'b1, 33, "R4 high unchanged");
        chk_phase(1'b0, 77, "R4 new low");
        repeat (3) @(negedge clk);
        swal = 3'd0; mainv = 4'd3;
        chk_phase(1'b1, 77 - 3, "R4 high unchanged 2");
        chk_phase(1'b0, 24, "R4 new low 2");

        // R5: standby mid-period.
        sby = 1'b1; swal = 3'd2; mainv = 4'd5;
        repeat (2) @(negedge clk);
        sby = 1'b0;
        phase_s(1'b0, n);
        repeat (10) @(negedge clk);
        sby = 1'b1;
        @(negedge clk);
        chk(dout == 1'b0, "R5 standby low", dout, 0);
        swal = 3'd3; mainv = 4'd6;
        repeat (20) @(negedge clk);
        chk(dout == 1'b0, "R5 standby held", dout, 0);
        sby = 1'b0;
        chk_phase(1'b0, SP * 6 + 3, "R5 release rise");

        // R7: default widths, full-size example.
        rst_n = 1'b0;
        @(negedge clk);
        d_rst_n = 1'b1;
        phase_d(1'b0, n);
        chk(n == 36240, "R7 low half", n, 36240);
        phase_d(1'b1, n);
        chk(n == 36240, "R7 high half", n, 36240);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule